// File: doc/BRIEF.md
# Timer Clock Prescaler and Selector

This block turns one system clock into single-cycle count-enable pulses for four timer counters. The pulses serve Timer 0, Timer 1, and the low and high halves of Timer 2. One shared prescaler makes a slow tick. Its ratio is picked by a 2-bit field: three ratios divide the system clock, and the fourth counts rising edges of an asynchronous external clock. The external clock is first brought into the system domain by a flop chain. The external clock must not run faster than the system clock.

An 8-bit configuration register holds the prescale field and one clock-select bit per timer. A select bit of 1 enables its timer on every system cycle. A select bit of 0 gives it the slow tick. Each timer's counter-mode and split-mode flags come in as inputs and can override its select bit. Timer 2 also has an alternate-source input. It chooses between the prescaled tick and the external clock divided by eight. The counters that consume these enables are outside the block.

Top module: `timer_clk_sel`

## Requirements
- R1: After reset the register reads 0x00. Bit 7 and bit 2 always read 0 and ignore writes. Bits 6..3 and 1..0 read back what was written, and reads are combinational from the stored value.
- R2: The prescale field sits in bits 1..0. With field 00 the prescaled tick is high for exactly one cycle in every 12. Counting from 0 at the cycle after the field changed, the tick is high when the count modulo 12 is 11.
- R3: With field 01 the tick is high once every 4 cycles, at count modulo 4 equal to 3. With field 10 it is high once every 48 cycles, at count modulo 48 equal to 47.
- R4: With field 11 the tick is high for one cycle on every eighth rising edge of the external clock. The edges are seen after a two-flop synchronizer and edge detection. No tick is produced while the external clock is idle.
- R5: A write that changes the prescale field restarts the prescaler and the external edge counter from zero. A write that leaves the field unchanged does not disturb the prescaler phase.
- R6: Bit 3 is the Timer 0 select and bit 4 is the Timer 1 select. A value of 1 makes that timer's enable high on every cycle. A value of 0 makes it follow the prescaled tick.
- R7: While a timer's counter-mode input is 1, its enable output is held low, whatever its select bit says.
- R8: Bit 5 is the Timer 2 low-half select. A value of 1 makes the low enable high every cycle. A value of 0 gives it the alternate clock. The alternate clock is the prescaled tick when the alternate-source input is 0, and the external clock divided by 8 when that input is 1.
- R9: Bit 6 is the Timer 2 high-half select. In split mode, 1 makes the high enable high every cycle and 0 gives it the alternate clock. Outside split mode the high enable equals the low enable, and bit 6 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 8 | Register write data |
| cfgRdData | output | 8 | Register read data |
| extClk | input | 1 | Asynchronous external clock |
| t0CountMode | input | 1 | Timer 0 is in counter mode |
| t1CountMode | input | 1 | Timer 1 is in counter mode |
| t2Split | input | 1 | Timer 2 is in split 8-bit mode |
| t2AltSel | input | 1 | Timer 2 alternate source: 0 prescaled tick, 1 external divided by 8 |
| t0En | output | 1 | Timer 0 count enable |
| t1En | output | 1 | Timer 1 count enable |
| t2LoEn | output | 1 | Timer 2 (low half in split mode) count enable |
| t2HiEn | output | 1 | Timer 2 high half count enable |

## Verification
Every one of the 128 register values is written after a forced change of the prescale field. This puts the prescaler at a known phase. The four mode flags are then stepped through all sixteen combinations, cycle by cycle, over one full 48-cycle period. This separates a wrong ratio or phase from a wrong select bit, a missing counter-mode override and a mis-wired split path. A write that leaves the field unchanged is placed mid-period, to tell a phase-preserving write from a restart. A slow external clock with sixteen rising edges is run twice. In prescale mode 11 it checks the divide-by-8 path. Through the Timer 2 alternate source, while the system divider also runs, it shows that the two paths are independent.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int REG_W  = 8;
  localparam int B_T2HI = 6;
  localparam int B_T2LO = 5;
  localparam int B_T1   = 4;
  localparam int B_T0   = 3;
  localparam logic [REG_W-1:0] RD_MASK = 8'h7B;

  typedef struct packed {
    logic       clearPre;
    logic [1:0] presc;
    logic       t0Sys;
    logic       t1Sys;
    logic       t2LoSys;
    logic       t2HiSys;
  } tcs_ctrl_t;
endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output tcs_ctrl_t        ctrl
);
  logic [REG_W-1:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     regQ <= '0;
    else if (wrEn) regQ <= wrData & RD_MASK;
  end

  assign rdData        = regQ;
  assign ctrl.clearPre = wrEn && (wrData[1:0] != regQ[1:0]);
  assign ctrl.presc    = regQ[1:0];
  assign ctrl.t0Sys    = regQ[B_T0];
  assign ctrl.t1Sys    = regQ[B_T1];
  assign ctrl.t2LoSys  = regQ[B_T2LO];
  assign ctrl.t2HiSys  = regQ[B_T2HI];

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData)); // R1
endmodule

// File: rtl/tcs_dp.sv
module tcs_dp
  import tcs_pkg::*;
#(
  parameter int DIV0        = 12,
  parameter int DIV1        = 4,
  parameter int DIV2        = 48,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  tcs_ctrl_t ctrl,
  input  logic      extClk,
  input  logic      t0CountMode,
  input  logic      t1CountMode,
  input  logic      t2Split,
  input  logic      t2AltSel,
  output logic      t0En,
  output logic      t1En,
  output logic      t2LoEn,
  output logic      t2HiEn
);
  localparam int MAX01  = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAXDIV = (MAX01 > DIV2) ? MAX01 : DIV2;
  localparam int CNT_W  = $clog2(MAXDIV);
  localparam int EXT_W  = $clog2(EXT_DIV);

  // external clock synchronizer and edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic                   extRise;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= extClk;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[SYNC_STAGES-1];

  assign extRise = syncQ[SYNC_STAGES-1] & ~lastQ;

  // external edge divider
  logic [EXT_W-1:0] extCnt;
  logic             extTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              extCnt <= '0;
    else if (ctrl.clearPre) extCnt <= '0;
    else if (extRise)       extCnt <= (extCnt == EXT_W'(EXT_DIV-1)) ? '0 : extCnt + 1'b1;
  end

  assign extTick = extRise && (extCnt == EXT_W'(EXT_DIV-1));

  // system clock prescaler
  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] termCnt;
  logic             sysMode;
  logic             preTick;

  always_comb begin
    case (ctrl.presc)
      2'b00:   termCnt = CNT_W'(DIV0-1);
      2'b01:   termCnt = CNT_W'(DIV1-1);
      2'b10:   termCnt = CNT_W'(DIV2-1);
      default: termCnt = '0;
    endcase
  end

  assign sysMode = (ctrl.presc != 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              preCnt <= '0;
    else if (ctrl.clearPre) preCnt <= '0;
    else if (sysMode)       preCnt <= (preCnt == termCnt) ? '0 : preCnt + 1'b1;
  end

  assign preTick = sysMode ? (preCnt == termCnt) : extTick;

  // enable muxing
  logic t2Alt;
  assign t2Alt  = t2AltSel ? extTick : preTick;
  assign t0En   = !t0CountMode && (ctrl.t0Sys || preTick);
  assign t1En   = !t1CountMode && (ctrl.t1Sys || preTick);
  assign t2LoEn = ctrl.t2LoSys || t2Alt;
  assign t2HiEn = t2Split ? (ctrl.t2HiSys || t2Alt) : t2LoEn;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    preTick |=> !preTick); // R2
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearPre |=> (preCnt == '0 && extCnt == '0)); // R5
  AST_SYS_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    (!t0CountMode && ctrl.t0Sys) |-> t0En); // R6
  AST_COUNT_MODE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (t0CountMode |-> !t0En) and (t1CountMode |-> !t1En)); // R7
  AST_HI_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !t2Split |-> (t2HiEn == t2LoEn)); // R9
endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel
  import tcs_pkg::*;
#(
  parameter int DIV0        = 12,
  parameter int DIV1        = 4,
  parameter int DIV2        = 48,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  input  logic       extClk,
  input  logic       t0CountMode,
  input  logic       t1CountMode,
  input  logic       t2Split,
  input  logic       t2AltSel,
  output logic       t0En,
  output logic       t1En,
  output logic       t2LoEn,
  output logic       t2HiEn
);
  tcs_ctrl_t ctrl;

  tcs_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (cfgWrEn),
    .wrData (cfgWrData),
    .rdData (cfgRdData),
    .ctrl   (ctrl)
  );

  tcs_dp #(
    .DIV0        (DIV0),
    .DIV1        (DIV1),
    .DIV2        (DIV2),
    .EXT_DIV     (EXT_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .extClk      (extClk),
    .t0CountMode (t0CountMode),
    .t1CountMode (t1CountMode),
    .t2Split     (t2Split),
    .t2AltSel    (t2AltSel),
    .t0En        (t0En),
    .t1En        (t1En),
    .t2LoEn      (t2LoEn),
    .t2HiEn      (t2HiEn)
  );
endmodule

// File: tb/timer_clk_sel_bench.sv
module timer_clk_sel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       extClk = 1'b0;
  logic       t0CountMode = 1'b0, t1CountMode = 1'b0, t2Split = 1'b0, t2AltSel = 1'b0;
  logic       t0En, t1En, t2LoEn, t2HiEn;

  int  checks = 0;
  int  errors = 0;
  int  pulse0 = 0;
  int  pulse2 = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  timer_clk_sel u_timer_clk_sel (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .extClk(extClk), .t0CountMode(t0CountMode),
    .t1CountMode(t1CountMode), .t2Split(t2Split), .t2AltSel(t2AltSel),
    .t0En(t0En), .t1En(t1En), .t2LoEn(t2LoEn), .t2HiEn(t2HiEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns at the negedge right after the write edge (phase k = 0)
  task automatic wrReg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic tickAt(input logic [1:0] p, input int k);
    case (p)
      2'b00:   return (k % 12) == 11;
      2'b01:   return (k % 4) == 3;
      2'b10:   return (k % 48) == 47;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sampleCount();
    #1;
    if (t0En) pulse0++;
    if (t2LoEn) pulse2++;
    @(negedge clk);
  endtask

  task automatic extRun(input int edges);
    pulse0 = 0;
    pulse2 = 0;
    for (int e = 0; e < edges; e++) begin
      extClk = 1'b1;
      repeat (3) sampleCount();
      extClk = 1'b0;
      repeat (3) sampleCount();
    end
    repeat (6) sampleCount();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] expV;
    logic       tk, alt, e0, e1, lo, hi;
    logic [3:0] f;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset readback", cfgRdData, 8'h00);
    chk("R2 reset enables", {t0En, t1En, t2LoEn, t2HiEn}, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;

    // R1 masked bits
    wrReg(8'hFF);
    #1 chk("R1 write ff", cfgRdData, 8'h7B);
    wrReg(8'h00);
    #1 chk("R1 write 00", cfgRdData, 8'h00);

    // exhaustive sweep: R2 R3 R6 R7 R8 R9
    for (int v = 0; v < 128; v++) begin
      wrReg(8'(v) ^ 8'h01);
      wrReg(8'(v));
      #1 chk("R1 readback", cfgRdData, 8'(v) & 8'h7B);
      for (int k = 0; k < 96; k++) begin
        if (k != 0) @(negedge clk);
        f = 4'(k + v);
        t0CountMode = f[0];
        t1CountMode = f[1];
        t2Split     = f[2];
        t2AltSel    = f[3];
        #1;
        tk   = tickAt(2'(v), k);
        alt  = f[3] ? 1'b0 : tk;
        e0   = f[0] ? 1'b0 : (v[3] ? 1'b1 : tk);
        e1   = f[1] ? 1'b0 : (v[4] ? 1'b1 : tk);
        lo   = v[5] ? 1'b1 : alt;
        hi   = f[2] ? (v[6] ? 1'b1 : alt) : lo;
        expV = {e0, e1, lo, hi};
        chk("R2 R3 R6 R7 R8 R9 sweep", {t0En, t1En, t2LoEn, t2HiEn}, expV);
      end
    end
    t0CountMode = 1'b0; t1CountMode = 1'b0; t2Split = 1'b0; t2AltSel = 1'b0;

    // R5: same-value write keeps phase
    wrReg(8'h01);
    wrReg(8'h00);
    repeat (2) @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = 8'h00;
    @(negedge clk);
    cfgWrEn = 1'b0;
    for (int k = 3; k < 30; k++) begin
      if (k != 3) @(negedge clk);
      #1 chk("R5 same-value write keeps phase", t0En, tickAt(2'b00, k));
    end

    // R5: changing write restarts mid-period
    repeat (5) @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = 8'h01;
    @(negedge clk);
    cfgWrEn = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (k != 0) @(negedge clk);
      #1 chk("R5 change restarts", t0En, tickAt(2'b01, k));
    end

    // R4: external clock divided by 8 via prescale 11
    wrReg(8'h01);
    wrReg(8'h03);
    t2AltSel = 1'b1;
    extRun(16);
    chk("R4 ext prescale pulses t0", pulse0, 2);
    chk("R8 ext alt pulses t2 low", pulse2, 2);

    // R8: alternate source independent of system divider
    wrReg(8'h01);
    wrReg(8'h00);
    t2AltSel = 1'b1;
    extRun(16);
    chk("R8 alt ext pulses t2 low", pulse2, 2);
    chk("R2 sys div12 pulses t0", pulse0, 8);

    // R4: idle external clock gives no ticks
    wrReg(8'h01);
    wrReg(8'h03);
    pulse0 = 0;
    repeat (60) sampleCount();
    chk("R4 idle ext no tick", pulse0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule